// File: doc/BRIEF.md
# Counted Fixed-Point Multiply-Accumulate Unit

This block forms a running dot product of two streams of signed two's-complement fixed-point operands. On every active clock edge it takes one operand pair, forms the product at full precision and adds it into a wide accumulator. A counter tracks how many pairs have been taken. When that number reaches the programmed total, the block raises a ready flag and freezes the result until the next reset.

The x operand has the format (XW, XF) and the y operand has the format (YW, YF). The product keeps (XW+YW, XF+YF) bits. The accumulator keeps the same binary point and adds CNT_W guard bits on top of the product width. With this width, no sequence of up to 2^CNT_W-1 products can overflow it. The count input must be loaded while reset is held and kept stable for the whole run. The caller then presents one pair per cycle, starting on the third rising edge after reset is released.

Top module: `fxp_dot_acc`

## Requirements
- R1: Driving rst_n low clears mac to zero and drives ready low at once, without waiting for a clock edge. The internal release is synchronised through two flops. No pair is taken on the first two rising edges after rst_n rises; ready stays 0 and mac stays 0 across them.
- R2: While running, exactly one (x_op, y_op) pair is taken on each rising edge. Its signed product, at full precision (XW+YW bits, XF+YF fraction bits), is added into mac.
- R3: mac is XW+YW+CNT_W bits wide, signed, with XF+YF fraction bits. The full count of 2^CNT_W-1 products at either the largest positive value or the most negative value must produce the exact sum with no wrap.
- R4: ready goes from 0 to 1 on the same rising edge that adds the n_count-th product. Before that edge it reads 0.
- R5: With n_count equal to 0, ready rises on the first active edge and mac stays 0.
- R6: Once ready is 1, further x_op and y_op values have no effect. mac and ready hold their values until the next reset.
- R7: Products of mixed sign are formed correctly. The sum over all pairs of x and y values in the operand range equals the product of the two operand sums.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| x_op | input | XW | First operand, signed, XF fraction bits |
| y_op | input | YW | Second operand, signed, YF fraction bits |
| n_count | input | CNT_W | Number of pairs to accumulate; held stable during a run |
| mac | output | XW+YW+CNT_W | Accumulated signed sum, XF+YF fraction bits |
| ready | output | 1 | Set once n_count products have been added |

## Verification
Two things can happen in the same cycle: the last addition and the rise of ready. The bench makes this happen in every run, for counts of 1, 3, 256, 1000 and 1023. It also covers a count of 0, where the rise of ready happens with no addition at all.

On the edge before the last one, ready must still be low. On the negative edge right after the last edge, ready must be high and mac must already hold the complete sum. An off-by-one either way shows up as a missing or extra product, or as a flag that comes one cycle early or late. After ready rises, further changes on the operands must leave mac unchanged.

// File: rtl/fxp_mac_pkg.sv
package fxp_mac_pkg;

  // Full-precision product width for two signed words.
  function automatic int prod_width(input int xw, input int yw);
    return xw + yw;
  endfunction

  // Accumulator width: one guard bit per count bit, so the largest
  // programmable count of products cannot overflow.
  function automatic int acc_width(input int xw, input int yw, input int cw);
    return xw + yw + cw;
  endfunction

endpackage

// File: rtl/fxp_rst_sync.sv
module fxp_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic meta_q;
  logic hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      hold_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      hold_q <= meta_q;
    end
  end

  assign rst_sync_n = hold_q;

endmodule

// File: rtl/fxp_mult.sv
module fxp_mult #(
  parameter int XW = 8,
  parameter int YW = 8,
  localparam int PW = XW + YW
) (
  input  logic [XW-1:0] x_op,
  input  logic [YW-1:0] y_op,
  output logic [PW-1:0] prod
);

  logic signed [PW-1:0] x_ext;
  logic signed [PW-1:0] y_ext;
  logic signed [PW-1:0] p_full;

  // Sign-extend both words to the product width so that the multiply is
  // done in signed arithmetic at full precision.
  always_comb begin
    x_ext  = {{(PW-XW){x_op[XW-1]}}, x_op};
    y_ext  = {{(PW-YW){y_op[YW-1]}}, y_op};
    p_full = x_ext * y_ext;
  end

  assign prod = p_full;

endmodule

// File: rtl/fxp_count_ctrl.sv
module fxp_count_ctrl #(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] n_count,
  output logic [CNT_W-1:0] cnt,
  output logic             acc_en,
  output logic             ready
);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             rdy_q, rdy_d;
  logic             upd;

  // Next state: either finish at once (count already met) or take one pair,
  // and raise ready together with the final pair.
  always_comb begin
    cnt_d  = cnt_q;
    rdy_d  = rdy_q;
    acc_en = 1'b0;
    if (!rdy_q) begin
      if (cnt_q == n_count) begin
        rdy_d = 1'b1;
      end else begin
        acc_en = 1'b1;
        cnt_d  = cnt_q + 1'b1;
        if (cnt_d == n_count) begin
          rdy_d = 1'b1;
        end
      end
    end
  end

  assign upd = !rdy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      rdy_q <= 1'b0;
    end else if (upd) begin
      cnt_q <= cnt_d;
      rdy_q <= rdy_d;
    end
  end

  assign cnt   = cnt_q;
  assign ready = rdy_q;

endmodule

// File: rtl/fxp_accum.sv
module fxp_accum #(
  parameter int PW = 16,
  parameter int AW = 26
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          acc_en,
  input  logic [PW-1:0] prod,
  output logic [AW-1:0] acc
);

  logic [AW-1:0] acc_q, acc_d;
  logic [AW-1:0] prod_ext;

  // The binary point of the product and the accumulator line up, so the
  // product only needs sign extension into the guard bits.
  always_comb begin
    prod_ext = {{(AW-PW){prod[PW-1]}}, prod};
    acc_d    = acc_q + prod_ext;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
    end else if (acc_en) begin
      acc_q <= acc_d;
    end
  end

  assign acc = acc_q;

endmodule

// File: rtl/fxp_dot_acc.sv
module fxp_dot_acc
  import fxp_mac_pkg::*;
#(
  parameter int XW    = 8,
  parameter int XF    = 3,
  parameter int YW    = 8,
  parameter int YF    = 2,
  parameter int CNT_W = 10,
  localparam int PW   = prod_width(XW, YW),
  localparam int AW   = acc_width(XW, YW, CNT_W)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [XW-1:0]    x_op,
  input  logic [YW-1:0]    y_op,
  input  logic [CNT_W-1:0] n_count,
  output logic [AW-1:0]    mac,
  output logic             ready
);

  // The result carries XF+YF fraction bits; the fraction lengths must fit
  // inside their words.
  if (XF > XW || YF > YW) begin : g_frac_guard
    $error("fraction length exceeds word length");
  end

  logic             rst_sync_n;
  logic [PW-1:0]    prod;
  logic [CNT_W-1:0] cnt_q;
  logic             acc_en;

  fxp_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  fxp_mult #(.XW(XW), .YW(YW)) u_mult (
    .x_op (x_op),
    .y_op (y_op),
    .prod (prod)
  );

  fxp_count_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .n_count (n_count),
    .cnt     (cnt_q),
    .acc_en  (acc_en),
    .ready   (ready)
  );

  fxp_accum #(.PW(PW), .AW(AW)) u_accum (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .acc_en (acc_en),
    .prod   (prod),
    .acc    (mac)
  );

endmodule

// File: rtl/fxp_dot_acc_chk.sv
module fxp_dot_acc_chk #(
  parameter int CNT_W = 10,
  parameter int PW    = 16,
  parameter int AW    = 26
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rst_sync_n,
  input logic [CNT_W-1:0] n_i,
  input logic [CNT_W-1:0] cnt,
  input logic [PW-1:0]    prod,
  input logic [AW-1:0]    mac,
  input logic             ready
);

  logic [AW-1:0] prod_ext;
  logic          taking;

  assign prod_ext = {{(AW-PW){prod[PW-1]}}, prod};
  assign taking   = rst_sync_n && !ready && (cnt != n_i);

  // R1
  reset_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rst_sync_n |-> (mac == '0) && !ready);

  // R2
  acc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    taking |=> (mac == $past(mac) + $past(prod_ext)));

  // R2
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    taking |=> (cnt == $past(cnt) + 1'b1));

  // R4
  ready_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready) |-> (cnt == n_i));

  // R5
  zero_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_sync_n && !ready && n_i == '0) |=> ready && (mac == '0));

  // R6
  ready_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ready |=> ready);

  // R6
  mac_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ready |=> $stable(mac));

endmodule

bind fxp_dot_acc fxp_dot_acc_chk #(.CNT_W(CNT_W), .PW(PW), .AW(AW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .rst_sync_n (rst_sync_n),
  .n_i        (n_count),
  .cnt        (cnt_q),
  .prod       (prod),
  .mac        (mac),
  .ready      (ready)
);

// File: tb/fxp_dot_acc_bench.sv
`timescale 1ns/100ps
module fxp_dot_acc_bench;

  localparam int XW    = 4;
  localparam int XF    = 2;
  localparam int YW    = 4;
  localparam int YF    = 1;
  localparam int CNT_W = 10;
  localparam int AW    = XW + YW + CNT_W;

  logic             clk;
  logic             rst_n;
  logic [XW-1:0]    x_op;
  logic [YW-1:0]    y_op;
  logic [CNT_W-1:0] n_count;
  logic [AW-1:0]    mac;
  logic             ready;

  int          checks;
  int          errors;
  bit          done;
  logic [31:0] seed;

  fxp_dot_acc #(.XW(XW), .XF(XF), .YW(YW), .YF(YF), .CNT_W(CNT_W)) u_fxp_dot_acc (
    .clk     (clk),
    .rst_n   (rst_n),
    .x_op    (x_op),
    .y_op    (y_op),
    .n_count (n_count),
    .mac     (mac),
    .ready   (ready)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic longint mac_val();
    return longint'($signed(mac));
  endfunction

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int sx4(input int v);
    int t;
    t = v & 15;
    return (t >= 8) ? t - 16 : t;
  endfunction

  // Operand patterns: 0 all pairs, 1 max positive product, 2 most negative
  // product, 3 pseudo-random.
  task automatic gen(input int mode, input int i, output int xv, output int yv);
    case (mode)
      0: begin xv = sx4(i >> 4); yv = sx4(i); end
      1: begin xv = -8; yv = -8; end
      2: begin xv = -8; yv = 7; end
      default: begin
        seed = seed * 32'd1664525 + 32'd1013904223;
        xv = sx4(int'(seed[31:28]));
        yv = sx4(int'(seed[27:24]));
      end
    endcase
  endtask

  task automatic do_reset(input int n);
    @(negedge clk);
    rst_n   = 1'b0;
    n_count = CNT_W'(n);
    x_op    = '0;
    y_op    = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic run(input int n, input int mode, input string req);
    longint exp;
    int xv, yv;
    exp = 0;
    do_reset(n);
    chk("R1", "mac in reset", mac_val(), 0);
    chk("R1", "ready in reset", longint'(ready), 0);
    // Two edges of synchronised release: nothing taken.
    x_op = 4'd7;
    y_op = 4'd7;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    chk("R1", "mac after release edges", mac_val(), 0);
    chk("R1", "ready after release edges", longint'(ready), 0);
    for (int i = 0; i < n; i++) begin
      gen(mode, i, xv, yv);
      x_op = XW'(xv);
      y_op = YW'(yv);
      exp += longint'(xv * yv);
      if (i == n - 1) chk("R4", "ready before last edge", longint'(ready), 0);
      @(posedge clk);
      @(negedge clk);
    end
    if (n == 0) begin
      @(posedge clk);
      @(negedge clk);
      chk("R5", "ready with zero count", longint'(ready), 1);
    end
    chk("R4", "ready with last product", longint'(ready), 1);
    chk(req, "sum", mac_val(), exp);
    // R6: operands after ready are ignored.
    for (int k = 0; k < 4; k++) begin
      x_op = XW'(k + 5);
      y_op = YW'(3 - k);
      @(posedge clk);
      @(negedge clk);
    end
    chk("R6", "mac frozen", mac_val(), exp);
    chk("R6", "ready held", longint'(ready), 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    checks  = 0;
    errors  = 0;
    done    = 1'b0;
    seed    = 32'h1234_5678;
    rst_n   = 1'b0;
    n_count = '0;
    x_op    = '0;
    y_op    = '0;

    run(0,    1, "R5");
    run(1,    1, "R2");
    run(3,    3, "R2");
    run(256,  0, "R7");
    run(1023, 1, "R3");
    run(1023, 2, "R3");
    run(1000, 3, "R2");

    // R1: asynchronous clear in the middle of a run.
    do_reset(50);
    repeat (2) @(posedge clk);
    x_op = 4'h8;
    y_op = 4'h8;
    repeat (20) @(posedge clk);
    @(negedge clk);
    chk("R1", "mac before mid-run reset", mac_val(), 64 * 20);
    #1;
    rst_n = 1'b0;
    #1;
    chk("R1", "mac cleared without edge", mac_val(), 0);
    chk("R1", "ready cleared without edge", longint'(ready), 0);
    @(negedge clk);
    rst_n = 1'b1;

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule